// File: doc/BRIEF.md
# Constant Off-Time PWM Current Chopper

This block regulates the current in one winding of a motor bridge by chopping. While the bridge is on, it watches a synchronized comparator flag that reports "winding current above reference". Once that flag is allowed to act, it turns the bridge off for a fixed, programmed number of clock cycles and then turns it back on. The off time is held constant; the switching period varies with the load.

Each on phase begins with a blanking window. During this window the comparator is ignored, so the current spike at turn-on cannot start a new off interval at once. A minimum on time is also enforced, regardless of the comparator. A comparator trip seen while either window is open is held off. It acts at the first on cycle after both windows have closed, but only if the comparator is still high then.

All three timing values are register inputs counted in clock cycles. At a 50 MHz clock the defaults are about 1 µs of blanking, 2.5 µs of minimum on time and 6.6 µs of off time. The bridge enable input drops the block into an idle-off state with its timers cleared. When enable returns, the block restarts in the on phase with a fresh blanking window.

Top module: `pwm_chopper`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, bridge_on, chopping and blanking are all 0.
- R2: When enable is sampled high at a clock edge while idle, bridge_on is 1 after that edge, and the on phase counts from on-cycle 1.
- R3: During on-cycles 1 to blank_cycles, blanking is 1 and the comparator is ignored. With blank_cycles = 0, blanking stays 0.
- R4: An on phase lasts at least min_on_cycles cycles, whatever the comparator does.
- R5: The comparator is sampled only at on-cycles greater than blank_cycles and at least min_on_cycles. If it is high at such an edge, bridge_on falls and chopping rises at that edge. With the comparator held high, an on phase lasts max(min_on_cycles, blank_cycles+1) cycles.
- R6: chopping stays 1 for exactly off_cycles cycles (1 cycle when off_cycles = 0). The bridge then turns on again with a fresh blanking window, as in R3.
- R7: A comparator trip seen only inside the masked window does not act if the comparator has fallen by the time the window ends. The bridge then stays on for as long as the comparator stays low.
- R8: An edge that samples enable low sends the block to idle. All outputs are 0 after that edge and the timers are cleared. The comparator has no effect while enable is low.
- R9: off_cycles is captured at the trip edge. A change to it during an off interval does not alter that interval's length.
- R10: bridge_on and chopping are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bridge enable; low forces idle-off |
| over_ref_i | input | 1 | Synchronized comparator: current above reference |
| blank_cycles_i | input | ON_W | Blanking window length in cycles |
| min_on_cycles_i | input | ON_W | Minimum on time in cycles |
| off_cycles_i | input | OFF_W | Fixed off interval in cycles |
| bridge_on_o | output | 1 | Bridge on request to the gate logic |
| chopping_o | output | 1 | High for the whole of each off interval |
| blanking_o | output | 1 | High while the comparator is masked by blanking |

## Verification
A comparator held high measures the bare cycle counts. It shows which of the two windows sets the on length (blanking longer than minimum on, or the reverse) and how long the off interval is, including the zero-value case. A comparator that pulses high only inside the masked window, then stays low, separates a trip that waits for the window to end from one that was latched and would fire anyway. Changing the off value during an off interval, and dropping enable in the middle of a phase, show when the off value is captured and how the block clears itself. Long random runs of comparator noise, enable drops and changing timing values are compared cycle by cycle against a bench model of the on, off and idle phases.

// File: rtl/pwm_chop_pkg.sv
package pwm_chop_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;
endpackage

// File: rtl/pwm_on_window.sv
module pwm_on_window #(
  parameter int ON_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic            run_i,
  input  logic [ON_W-1:0] blank_cycles_i,
  input  logic [ON_W-1:0] min_on_cycles_i,
  output logic            in_blank_o,
  output logic            done_o
);
  localparam logic [ON_W-1:0] CntMax = {ON_W{1'b1}};
  localparam logic [ON_W-1:0] CntOne = ON_W'(1);

  logic [ON_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  // on-cycle index, 1 on the first on cycle, saturating
  always_comb begin
    cnt_en = clr_i | start_i | (run_i & (cnt_q != CntMax));
    cnt_d  = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (start_i) cnt_d = CntOne;
    else if (run_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign in_blank_o = (cnt_q != '0) && (cnt_q <= blank_cycles_i);
  assign done_o     = (cnt_q >= min_on_cycles_i) && (cnt_q > blank_cycles_i);

  // R2: a fresh on phase always starts outside the completed state unless windows are zero
  a_r2_fresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> (cnt_q == CntOne))
    else $error("a_r2_fresh_start");
endmodule

// File: rtl/pwm_off_timer.sv
module pwm_off_timer #(
  parameter int OFF_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [OFF_W-1:0] load_val_i,
  output logic             expire_o
);
  localparam logic [OFF_W-1:0] CntOne = OFF_W'(1);

  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | load_i | (run_i & ~expire_o);
    cnt_d  = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else if (run_i)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q <= CntOne);

  // R9: a loaded interval longer than one cycle is not over on the next cycle
  a_r9_load_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && (load_val_i > CntOne)) |=> !expire_o)
    else $error("a_r9_load_holds");
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import pwm_chop_pkg::*;
#(
  parameter int ON_W  = 10,
  parameter int OFF_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             over_ref_i,
  input  logic [ON_W-1:0]  blank_cycles_i,
  input  logic [ON_W-1:0]  min_on_cycles_i,
  input  logic [OFF_W-1:0] off_cycles_i,
  output logic             bridge_on_o,
  output logic             chopping_o,
  output logic             blanking_o
);
  phase_t ph_q, ph_d;
  logic   win_done, win_blank, off_exp;
  logic   trip, win_start, win_run, off_load, off_run, tmr_clr;

  assign trip = (ph_q == PH_ON) && win_done && over_ref_i;

  always_comb begin
    ph_d = ph_q;
    if (!en_i) ph_d = PH_IDLE;
    else begin
      unique case (ph_q)
        PH_IDLE: ph_d = PH_ON;
        PH_ON:   if (trip)    ph_d = PH_OFF;
        PH_OFF:  if (off_exp) ph_d = PH_ON;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  assign tmr_clr   = !en_i;
  assign win_start = en_i && ((ph_q == PH_IDLE) || ((ph_q == PH_OFF) && off_exp));
  assign win_run   = en_i && (ph_q == PH_ON);
  assign off_load  = en_i && trip;
  assign off_run   = en_i && (ph_q == PH_OFF);

  pwm_on_window #(.ON_W(ON_W)) u_win (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clr_i           (tmr_clr),
    .start_i         (win_start),
    .run_i           (win_run),
    .blank_cycles_i  (blank_cycles_i),
    .min_on_cycles_i (min_on_cycles_i),
    .in_blank_o      (win_blank),
    .done_o          (win_done)
  );

  pwm_off_timer #(.OFF_W(OFF_W)) u_off (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (tmr_clr),
    .load_i     (off_load),
    .run_i      (off_run),
    .load_val_i (off_cycles_i),
    .expire_o   (off_exp)
  );

  assign bridge_on_o = (ph_q == PH_ON);
  assign chopping_o  = (ph_q == PH_OFF);
  assign blanking_o  = (ph_q == PH_ON) && win_blank;

  // R5: an allowed comparator trip starts an off interval at that edge
  a_r5_trip_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bridge_on_o && win_done && over_ref_i && en_i) |=> chopping_o)
    else $error("a_r5_trip_off");

  // R4: the bridge cannot leave the on phase before both windows close
  a_r4_hold_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bridge_on_o && !win_done && en_i) |=> bridge_on_o)
    else $error("a_r4_hold_on");

  // R3: blanking masks the comparator
  a_r3_blank_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blanking_o && en_i) |=> !chopping_o)
    else $error("a_r3_blank_mask");

  // R6: the end of an off interval turns the bridge on again
  a_r6_reenter_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chopping_o && off_exp && en_i) |=> bridge_on_o)
    else $error("a_r6_reenter_on");

  // R8: enable low idles everything
  a_r8_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bridge_on_o && !chopping_o && !blanking_o))
    else $error("a_r8_disable_idle");

  // R10: on and off requests are exclusive
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bridge_on_o && chopping_o))
    else $error("a_r10_exclusive");
endmodule

// File: tb/pwm_chopper_tb.sv
`timescale 1ns/1ps
module pwm_chopper_tb;
  localparam int ON_W  = 10;
  localparam int OFF_W = 19;
  localparam int ON_MAX = (1 << ON_W) - 1;

  logic             clk, rst_n, en, ovr;
  logic [ON_W-1:0]  blk, mon;
  logic [OFF_W-1:0] offc;
  logic             bon, chop, blnk;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_live = 0;

  pwm_chopper #(.ON_W(ON_W), .OFF_W(OFF_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .over_ref_i(ovr),
    .blank_cycles_i(blk), .min_on_cycles_i(mon), .off_cycles_i(offc),
    .bridge_on_o(bon), .chopping_o(chop), .blanking_o(blnk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_on_len(int b, int n);
    return (n > b + 1) ? n : b + 1;
  endfunction
  function automatic int exp_off_len(int o);
    return (o == 0) ? 1 : o;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 on, 2 off
  int m_ph, m_on, m_off;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_on = 0; m_off = 0;
    end else if (!en) begin
      m_ph = 0; m_on = 0; m_off = 0;
    end else begin
      case (m_ph)
        0: begin m_ph = 1; m_on = 1; end
        1: if (ovr && m_on >= int'(mon) && m_on > int'(blk)) begin
             m_ph = 2; m_off = int'(offc);
           end else if (m_on < ON_MAX) m_on = m_on + 1;
        default: if (m_off <= 1) begin m_ph = 1; m_on = 1; end
                 else m_off = m_off - 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_live) begin
      check("R2-R8 model bridge_on", int'(bon), int'(m_ph == 1));
      check("R6 model chopping", int'(chop), int'(m_ph == 2));
      check("R3 model blanking", int'(blnk), int'(m_ph == 1 && m_on <= int'(blk)));
      check("R10 exclusive", int'(bon && chop), 0);
    end
  end

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // from idle: raise enable, measure on and off lengths with comparator high
  task automatic measure(int b, int n, int o, int o_change, string tag);
    int c_on, c_off;
    en = 1'b0; ovr = 1'b1;
    blk = ON_W'(b); mon = ON_W'(n); offc = OFF_W'(o);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    c_on = 0;
    while (bon) begin c_on++; @(negedge clk); end
    if (o_change >= 0) offc = OFF_W'(o_change);
    c_off = 0;
    while (chop) begin c_off++; @(negedge clk); end
    check({tag, " on length"}, c_on, exp_on_len(b, n));
    check({tag, " off length"}, c_off, exp_off_len(o));
    check({tag, " re-on after off"}, int'(bon), 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; en = 1'b0; ovr = 1'b0;
    blk = 10'd3; mon = 10'd5; offc = 19'd4;
    repeat (3) @(negedge clk);
    check("R1 reset bridge_on", int'(bon), 0);
    check("R1 reset chopping", int'(chop), 0);
    check("R1 reset blanking", int'(blnk), 0);
    rst_n = 1'b1;
    model_live = 1;
    @(negedge clk);
    check("R1 after release", int'(bon | chop | blnk), 0);

    // R2 and R3: first on cycle and blanking
    en = 1'b1; ovr = 1'b1;
    @(negedge clk);
    check("R2 on after enable", int'(bon), 1);
    check("R3 blanking first cycle", int'(blnk), 1);

    measure(3, 6, 5, -1, "R4 min-on dominates");
    measure(7, 2, 4, -1, "R5 blanking dominates");
    measure(0, 0, 0, -1, "R6 zero off");
    measure(0, 1, 9, -1, "R6 long off");
    measure(1, 1, 8, 2, "R9 off captured");

    // R3 with zero blanking: blanking never seen
    en = 1'b0; blk = 10'd0; mon = 10'd3; ovr = 1'b0;
    @(negedge clk); en = 1'b1; @(negedge clk);
    check("R3 zero blank", int'(blnk), 0);

    // R7: pulse inside masked window then drop
    en = 1'b0; blk = 10'd4; mon = 10'd4; offc = 19'd3; ovr = 1'b1;
    @(negedge clk); en = 1'b1;
    @(negedge clk); @(negedge clk);
    ovr = 1'b0;
    repeat (15) @(negedge clk);
    check("R7 dropped trip ignored on", int'(bon), 1);
    check("R7 dropped trip no chop", int'(chop), 0);
    ovr = 1'b1;
    @(negedge clk);
    check("R5 late trip chops", int'(chop), 1);

    // R8: drop enable mid on phase, comparator toggling
    ovr = 1'b0;
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R8 idle bridge_on", int'(bon), 0);
    for (int i = 0; i < 8; i++) begin
      ovr = ~ovr;
      @(negedge clk);
      check("R8 idle stays off", int'(bon | chop | blnk), 0);
    end
    en = 1'b1;
    @(negedge clk);
    check("R8 restart with blanking", int'(blnk), 1);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      if ((k % 97) == 0) begin
        blk  = ON_W'($urandom % 6);
        mon  = ON_W'($urandom % 9);
        offc = OFF_W'($urandom % 11);
      end
      ovr = (($urandom % 4) != 0);
      if (($urandom % 120) == 0) en = ~en;
      else if (!en && ($urandom % 6) == 0) en = 1'b1;
      @(negedge clk);
    end

    model_live = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule